// File: doc/BRIEF.md
# Link power status interface controller

This block decides whether the parallel interface between a physical-layer device and its link-layer controller is live, held in reset, or shut down. It samples a single link power status level once per system-clock cycle and tracks how long that level has been low without a break. A short low, including the low half of a pulsed power-good signal, is tolerated. A sustained low first drops the interface into a reset state. A longer low then drops it into a disabled state.

In the reset state the control and data output drivers and the request input are gated, but the clock toward the link keeps running. In the disabled state the clock is gated as well. A hardware reset starts the interface in the disabled state. Once the status input is seen active again and the physical layer signals that it is ready, the interface goes through a short re-initialisation window with outputs held off and then becomes active. The registered status-active flag is exported for neighbouring blocks. The state encoding is ACTIVE = 0, RESET = 1, DISABLED = 2, INIT = 3.

Top module: `lps_link_ctrl`

## Requirements
- R1: `lps_active` goes to 0 on the clock edge that samples the 129th consecutive low value of `lps_in`. A low run of 128 samples or fewer, including a pulsed input with low phases of at most 128 cycles, leaves `lps_active` at 1.
- R2: Any edge that samples `lps_in` high sets `lps_active` to 1 at that edge and restarts the low run from zero.
- R3: In ACTIVE or INIT, one edge after `lps_active` is seen at 0 the state becomes RESET (code 1). In RESET, `ctl_out_en`, `data_out_en` and `req_in_en` are 0 and `sysclk_en` is 1.
- R4: In RESET, the edge after the low run has exceeded 1280 samples moves the state to DISABLED (code 2), where `sysclk_en` is also 0. A low run of exactly 1280 samples keeps the state in RESET. ACTIVE never moves straight to DISABLED.
- R5: While `rst_n` is low the state is DISABLED, `lps_active` is 0 and all four enables are 0.
- R6: From RESET or DISABLED, an edge at which `lps_active` is 1 and `phy_ready` is 1 moves the state to INIT (code 3). `phy_ready` alone, or `lps_active` alone, has no effect.
- R7: INIT lasts exactly 4 cycles, with the three gated enables at 0 and `sysclk_en` at 1. The state then becomes ACTIVE (code 0) with all four enables at 1.
- R8: `phy_ready` has no effect in ACTIVE or INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which `lps_in` is sampled |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| lps_in | input | 1 | Sampled link power status level |
| phy_ready | input | 1 | Strobe from the physical layer permitting re-initialisation |
| lps_active | output | 1 | Registered link power status active flag |
| if_state | output | 2 | Interface state: 0 ACTIVE, 1 RESET, 2 DISABLED, 3 INIT |
| ctl_out_en | output | 1 | Enable for the control outputs toward the link |
| data_out_en | output | 1 | Enable for the data outputs toward the link |
| req_in_en | output | 1 | Gate for the request input from the link |
| sysclk_en | output | 1 | Gate for the clock output toward the link |

## Verification
Two events can land on the same edge: the low run crosses the disable threshold, and the status input returns high while `phy_ready` is already asserted. The bench holds `lps_in` low for exactly 1281 samples and then raises it together with `phy_ready`. The expected result is one cycle in DISABLED with the clock gated, followed by INIT on the next edge, and never a skip straight from RESET to INIT. A behavioural model with an unbounded low-run integer and a countdown for the INIT window is compared with every output on every cycle. This covers both that collision and the neighbouring case of exactly 1280 lows.

// File: rtl/lps_link_ctrl.sv
module lps_link_ctrl #(
  parameter int LOW_LIMIT = 128,
  parameter int OFF_LIMIT = 1280,
  parameter int INIT_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lps_in,
  input  logic       phy_ready,
  output logic       lps_active,
  output logic [1:0] if_state,
  output logic       ctl_out_en,
  output logic       data_out_en,
  output logic       req_in_en,
  output logic       sysclk_en
);
  localparam int CNT_W  = $clog2(OFF_LIMIT + 2);
  localparam int INIT_W = (INIT_LEN > 1) ? $clog2(INIT_LEN) : 1;
  localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(OFF_LIMIT + 1);
  localparam logic [CNT_W-1:0]  LOW_TH    = CNT_W'(LOW_LIMIT);
  localparam logic [CNT_W-1:0]  OFF_TH    = CNT_W'(OFF_LIMIT);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_LEN - 1);
  localparam logic [1:0] S_ACTIVE = 2'd0;
  localparam logic [1:0] S_RESET  = 2'd1;
  localparam logic [1:0] S_OFF    = 2'd2;
  localparam logic [1:0] S_INIT   = 2'd3;

  logic [CNT_W-1:0]  low_cnt;
  logic [CNT_W-1:0]  low_cnt_nx;
  logic [INIT_W-1:0] init_cnt;
  logic [1:0]        state;
  logic [1:0]        state_nx;
  logic              wake;

  assign low_cnt_nx = lps_in ? '0 :
                      (low_cnt == CNT_SAT) ? low_cnt : low_cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt    <= CNT_SAT;
      lps_active <= 1'b0;
    end else begin
      low_cnt    <= low_cnt_nx;
      lps_active <= (low_cnt_nx <= LOW_TH);
    end
  end

  assign wake = lps_active & phy_ready;

  always_comb begin
    state_nx = state;
    case (state)
      S_ACTIVE: if (!lps_active) state_nx = S_RESET;
      S_RESET: begin
        if (wake)                  state_nx = S_INIT;
        else if (low_cnt > OFF_TH) state_nx = S_OFF;
      end
      S_OFF: if (wake) state_nx = S_INIT;
      default: begin
        if (!lps_active)                state_nx = S_RESET;
        else if (init_cnt == INIT_LAST) state_nx = S_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      init_cnt <= '0;
    end else begin
      state    <= state_nx;
      init_cnt <= (state == S_INIT && state_nx == S_INIT) ? init_cnt + INIT_W'(1) : '0;
    end
  end

  assign if_state    = state;
  assign ctl_out_en  = (state == S_ACTIVE);
  assign data_out_en = (state == S_ACTIVE);
  assign req_in_en   = (state == S_ACTIVE);
  assign sysclk_en   = (state != S_OFF);
endmodule

module lps_link_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lps_in,
  input logic       phy_ready,
  input logic       lps_active,
  input logic [1:0] if_state,
  input logic       ctl_out_en,
  input logic       sysclk_en
);
  assert_fall_needs_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lps_active) |-> !$past(lps_in));

  assert_high_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lps_in |=> lps_active);

  assert_reset_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (if_state == 2'd1 && $past(if_state) != 2'd1) |-> !$past(lps_active));

  assert_no_skip_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (if_state == 2'd0) |=> (if_state != 2'd2));

  assert_clk_gate_only_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysclk_en) |-> $past(if_state) == 2'd1);

  assert_init_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (if_state == 2'd3 && $past(if_state) != 2'd3) |-> ($past(lps_active) && $past(phy_ready)));

  assert_active_via_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_out_en) |-> $past(if_state) == 2'd3);
endmodule

bind lps_link_ctrl lps_link_ctrl_chk u_lps_link_ctrl_chk (.*);

// File: tb/test_lps_link_ctrl.sv
module test_lps_link_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps_in = 1'b0;
  logic phy_ready = 1'b0;
  logic lps_active, ctl_out_en, data_out_en, req_in_en, sysclk_en;
  logic [1:0] if_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lps_link_ctrl i_lps_link_ctrl (
    .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .phy_ready(phy_ready),
    .lps_active(lps_active), .if_state(if_state), .ctl_out_en(ctl_out_en),
    .data_out_en(data_out_en), .req_in_en(req_in_en), .sysclk_en(sysclk_en)
  );

  // Behavioural reference: unbounded low-run length, countdown for INIT.
  int  m_run = 100000;
  bit  m_act = 1'b0;
  int  m_st  = 2;
  int  m_rem = 0;
  int  p_run, p_st;
  bit  p_act;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 100000; m_act = 1'b0; m_st = 2; m_rem = 0;
    end else begin
      p_run = m_run; p_act = m_act; p_st = m_st;
      if (p_st == 0) begin
        if (!p_act) m_st = 1;
      end else if (p_st == 1 || p_st == 2) begin
        if (p_act && phy_ready) begin m_st = 3; m_rem = 4; end
        else if (p_st == 1 && p_run > 1280) m_st = 2;
      end else begin
        if (!p_act) m_st = 1;
        else begin
          m_rem = m_rem - 1;
          if (m_rem == 0) m_st = 0;
        end
      end
      if (lps_in) m_run = 0; else m_run = m_run + 1;
      m_act = (m_run <= 128);
    end
  end

  task automatic chk(string what, int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic string st_tag(int s);
    case (s)
      0: return "R7";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("state", int'(if_state), m_st, "R5");
        chk("lps_active", int'(lps_active), int'(m_act), "R5");
        chk("sysclk_en", int'(sysclk_en), 0, "R5");
        chk("ctl_out_en", int'(ctl_out_en), 0, "R5");
      end else begin
        chk("lps_active", int'(lps_active), int'(m_act), "R1");
        chk("state", int'(if_state), m_st, st_tag(m_st));
        chk("ctl_out_en", int'(ctl_out_en), int'(m_st == 0), "R3");
        chk("data_out_en", int'(data_out_en), int'(m_st == 0), "R3");
        chk("req_in_en", int'(req_in_en), int'(m_st == 0), "R3");
        chk("sysclk_en", int'(sysclk_en), int'(m_st != 2), "R4");
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    finish_run();
  end

  task automatic bring_up();
    phy_ready = 1'b1; cyc(1); phy_ready = 1'b0; cyc(6);
  endtask

  initial begin
    cyc(3);
    chk("state after hw reset", int'(if_state), 2, "R5");
    chk("lps_active after hw reset", int'(lps_active), 0, "R5");
    rst_n = 1'b1;
    lps_in = 1'b1; cyc(2);
    chk("still disabled without ready", int'(if_state), 2, "R6");
    bring_up();
    chk("active after bring-up", int'(if_state), 0, "R7");

    for (int i = 0; i < 5; i++) begin
      lps_in = 1'b0; cyc(128);
      lps_in = 1'b1; cyc(1);
    end
    chk("pulsed input keeps active flag", int'(lps_active), 1, "R1");
    chk("pulsed input keeps active state", int'(if_state), 0, "R1");

    lps_in = 1'b0; cyc(129);
    chk("flag low after 129 lows", int'(lps_active), 0, "R1");
    cyc(1);
    chk("reset state", int'(if_state), 1, "R3");
    chk("clock kept in reset", int'(sysclk_en), 1, "R3");
    phy_ready = 1'b1; cyc(2); phy_ready = 1'b0;
    chk("ready alone ignored", int'(if_state), 1, "R6");
    lps_in = 1'b1; cyc(1);
    chk("one high sample sets flag", int'(lps_active), 1, "R2");
    cyc(5);
    chk("flag alone does not wake", int'(if_state), 1, "R6");
    bring_up();
    chk("active again", int'(if_state), 0, "R7");

    phy_ready = 1'b1; cyc(3); phy_ready = 1'b0; cyc(1);
    chk("ready ignored in active", int'(if_state), 0, "R8");

    lps_in = 1'b0; cyc(1280);
    lps_in = 1'b1; cyc(3);
    chk("exactly 1280 lows stays reset", int'(if_state), 1, "R4");
    bring_up();

    lps_in = 1'b0; cyc(1281);
    lps_in = 1'b1; phy_ready = 1'b1; cyc(1);
    chk("1281 lows reach disabled", int'(if_state), 2, "R4");
    chk("clock gated when disabled", int'(sysclk_en), 0, "R4");
    cyc(1);
    chk("wake from disabled", int'(if_state), 3, "R6");
    cyc(1);
    chk("ready ignored in init", int'(if_state), 3, "R8");
    phy_ready = 1'b0; cyc(6);

    lps_in = 1'b0; cyc(2000);
    chk("long low disabled", int'(if_state), 2, "R4");
    lps_in = 1'b1; cyc(10);
    chk("disabled until ready", int'(if_state), 2, "R6");
    phy_ready = 1'b1; cyc(1); phy_ready = 1'b0;
    chk("init entered", int'(if_state), 3, "R7");
    chk("clock on in init", int'(sysclk_en), 1, "R7");
    cyc(3);
    chk("init still holding outputs", int'(ctl_out_en), 0, "R7");
    cyc(1);
    chk("active after 4 init cycles", int'(if_state), 0, "R7");

    rst_n = 1'b0; cyc(2);
    chk("hw reset mid-active", int'(if_state), 2, "R5");
    rst_n = 1'b1; lps_in = 1'b0; phy_ready = 1'b1; cyc(3); phy_ready = 1'b0;
    chk("ready with low input after reset", int'(if_state), 2, "R6");
    lps_in = 1'b1; cyc(1);
    bring_up();
    chk("final active", int'(if_state), 0, "R7");
    cyc(2);
    finish_run();
  end
endmodule